// File: doc/BRIEF.md
# FMA Special-Operand Override Unit

This block sits beside the arithmetic datapath of a single-precision fused multiply-add. It inspects the three binary32 operands (multiplicand A, multiplier B, addend C) and decides whether the final result is fixed by an operand class alone. Such classes are NaNs, infinities, and zero times infinity. When the result is fixed, the block supplies that result and the invalid-operation indication. When it is not fixed, it stays quiet and the arithmetic datapath owns the result.

Two sign controls select the operation variant. The product negation control flips the sign of A, which gives (-A·B)+C and is the same as -(A·B)+C. The result negation control gives -((A·B)+C). A mode input sets when these negations take effect relative to NaN propagation. In prefix mode the negations act as separate steps around a plain multiply-add, so a propagated NaN has its sign flipped. In fused mode the whole variant counts as a single operation, so a propagated NaN keeps its original sign. A policy bit sets whether zero times infinity plus a quiet NaN raises invalid-operation. A flush control makes denormal operands count as zero.

All decision logic is combinational. Its three outputs are captured in one register stage, so the outputs reflect the operands presented one clock earlier.

Top module: `fma_special_sel`

## Requirements
- R1: During reset and after it, before any capture, ovr_valid, ovr_result and invalid are all 0. Every output reflects the inputs sampled at the previous rising clock edge.
- R2: If any operand is a signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is the first signaling NaN in the order C, A, B. It is returned with fraction bit 22 set, and invalid is 1.
- R3: If no operand is signaling but some operand is a quiet NaN (fraction bit 22 set), the result is the first quiet NaN in the order C, A, B, returned unchanged apart from R4. invalid is 0 except as R6 states.
- R4: With neg_mode=0 (prefix negation), neg_prod flips bit 31 of A before NaN selection, and neg_res flips bit 31 of any propagated NaN.
- R5: With neg_mode=1 (fused negation), a propagated NaN keeps the bit 31 it had at the input, whatever neg_prod and neg_res are.
- R6: If one of A and B is zero and the other is infinite, and C is a quiet NaN, the result is C. invalid then equals inv_zinf_qnan.
- R7: If one of A and B is zero and the other is infinite, and C is not a NaN, the result is 0x7FC00000 and invalid is 1. This default NaN is never negated.
- R8: An infinite product (no zero factor) added to an infinite C of the opposite sign gives 0x7FC00000 with invalid 1. The product sign is sign(A) XOR sign(B) XOR neg_prod.
- R9: Any other case with an infinite product or an infinite C gives an infinity with invalid 0. Its sign is the product sign if the product is infinite and otherwise the sign of C, XOR neg_res.
- R10: With ftz=1 an operand with exponent 0 and nonzero fraction counts as zero, so it can form zero times infinity. With ftz=0 it is finite and nonzero.
- R11: If no operand is a NaN or an infinity, ovr_valid is 0. Whenever ovr_valid is 0, ovr_result and invalid are 0, and invalid is never 1 without ovr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | Multiplicand, binary32 |
| op_b | input | 32 | Multiplier, binary32 |
| op_c | input | 32 | Addend, binary32 |
| neg_prod | input | 1 | Negate the product (flip sign of A) |
| neg_res | input | 1 | Negate the final result |
| neg_mode | input | 1 | 0: prefix negation, 1: fused negation |
| inv_zinf_qnan | input | 1 | Raise invalid for zero×inf + quiet NaN |
| ftz | input | 1 | Treat denormal operands as zero |
| ovr_valid | output | 1 | Result is fixed by a special case |
| ovr_result | output | 32 | Fixed result, zero when not valid |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Two functions meet in one cycle when NaN propagation and the zero-times-infinity check both apply. This happens when a zero and an infinite factor face a quiet or signaling NaN addend. It also happens when a negated NaN competes with an invalid infinity combination. Directed vectors set up these overlaps under both negation modes and both policy settings, with and without flushing. A random mix of zeros, denormals, infinities and both NaN kinds with random signs produces the rest. A behavioural model in the bench judges every captured result, bit for bit, together with the two flags.

// File: rtl/fmasp_pkg.sv
package fmasp_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned FP_W   = 1 + EXP_W + FRAC_W;
  localparam int unsigned SGN_B  = FP_W - 1;
  localparam int unsigned QBIT   = FRAC_W - 1;
  localparam int unsigned N_OPS  = 3;

  localparam logic [FP_W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic sgn;
    logic zero;
    logic inf;
    logic qnan;
    logic snan;
  } fp_cls_t;

  typedef enum logic {
    NEG_PREFIX = 1'b0,
    NEG_FUSED  = 1'b1
  } neg_mode_e;
endpackage

// File: rtl/fmasp_classify.sv
module fmasp_classify
  import fmasp_pkg::*;
(
  input  logic [FP_W-1:0] op,
  input  logic            ftz,
  output fp_cls_t         cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              exp_min;
  logic              frac_nz;

  assign exp_f   = op[FP_W-2:FRAC_W];
  assign frac_f  = op[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls.sgn  = op[SGN_B];
    cls.zero = exp_min & (~frac_nz | ftz);
    cls.inf  = exp_max & ~frac_nz;
    cls.qnan = exp_max & frac_nz & frac_f[QBIT];
    cls.snan = exp_max & frac_nz & ~frac_f[QBIT];
  end
endmodule

// File: rtl/fmasp_nan_pick.sv
module fmasp_nan_pick
  import fmasp_pkg::*;
#(
  parameter int unsigned NOPS = N_OPS
) (
  input  logic [NOPS-1:0][FP_W-1:0] ops,
  input  logic [NOPS-1:0]           is_snan,
  input  logic [NOPS-1:0]           is_qnan,
  output logic                      nan_hit,
  output logic                      snan_hit,
  output logic [FP_W-1:0]           nan_val
);
  logic [NOPS-1:0]           gnt_s;
  logic [NOPS-1:0]           gnt_q;
  logic [NOPS-1:0]           gnt;
  logic [NOPS-1:0][FP_W-1:0] quieted;

  genvar gi;
  generate
    for (gi = 0; gi < NOPS; gi++) begin : g_quiet
      assign quieted[gi] = ops[gi] | (FP_W'(1) << QBIT);
    end
  endgenerate

  always_comb begin
    logic seen_s;
    logic seen_q;
    seen_s = 1'b0;
    seen_q = 1'b0;
    for (int i = 0; i < NOPS; i++) begin
      gnt_s[i] = is_snan[i] & ~seen_s;
      seen_s   = seen_s | is_snan[i];
      gnt_q[i] = is_qnan[i] & ~seen_q;
      seen_q   = seen_q | is_qnan[i];
    end
    snan_hit = seen_s;
    nan_hit  = seen_s | seen_q;
    gnt      = seen_s ? gnt_s : gnt_q;
  end

  always_comb begin
    nan_val = '0;
    for (int i = 0; i < NOPS; i++) begin
      if (gnt[i]) nan_val = nan_val | quieted[i];
    end
  end
endmodule

// File: rtl/fmasp_inf_resolve.sv
module fmasp_inf_resolve
  import fmasp_pkg::*;
(
  input  fp_cls_t cls_a,
  input  fp_cls_t cls_b,
  input  fp_cls_t cls_c,
  input  logic    neg_prod,
  output logic    zinf,
  output logic    inf_clash,
  output logic    inf_hit,
  output logic    inf_sgn
);
  logic prod_inf;
  logic prod_zero;
  logic prod_sgn;
  logic prod_inf_only;

  assign prod_inf      = cls_a.inf | cls_b.inf;
  assign prod_zero     = cls_a.zero | cls_b.zero;
  assign prod_sgn      = cls_a.sgn ^ cls_b.sgn ^ neg_prod;
  assign prod_inf_only = prod_inf & ~prod_zero;

  always_comb begin
    zinf      = prod_inf & prod_zero;
    inf_clash = prod_inf_only & cls_c.inf & (prod_sgn != cls_c.sgn);
    inf_hit   = prod_inf_only | cls_c.inf;
    inf_sgn   = prod_inf_only ? prod_sgn : cls_c.sgn;
  end
endmodule

// File: rtl/fma_special_sel.sv
module fma_special_sel
  import fmasp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FP_W-1:0] op_a,
  input  logic [FP_W-1:0] op_b,
  input  logic [FP_W-1:0] op_c,
  input  logic            neg_prod,
  input  logic            neg_res,
  input  logic            neg_mode,
  input  logic            inv_zinf_qnan,
  input  logic            ftz,
  output logic            ovr_valid,
  output logic [FP_W-1:0] ovr_result,
  output logic            invalid
);
  localparam logic [FP_W-1:0] SGN_MASK = FP_W'(1) << SGN_B;
  localparam logic [FP_W-1:0] INF_MAG  = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  neg_mode_e mode;
  assign mode = neg_mode_e'(neg_mode);

  // operand classification, raw signs
  fp_cls_t cls_a, cls_b, cls_c;
  fmasp_classify u_cls_a (.op(op_a), .ftz(ftz), .cls(cls_a));
  fmasp_classify u_cls_b (.op(op_b), .ftz(ftz), .cls(cls_b));
  fmasp_classify u_cls_c (.op(op_c), .ftz(ftz), .cls(cls_c));

  // prefix mode: the product negation lands on A before NaN selection
  logic [FP_W-1:0] a_eff;
  assign a_eff = (neg_prod && mode == NEG_PREFIX) ? (op_a ^ SGN_MASK) : op_a;

  // priority lanes: index 0 = C, 1 = A, 2 = B
  logic [N_OPS-1:0][FP_W-1:0] lane_ops;
  logic [N_OPS-1:0]           lane_snan;
  logic [N_OPS-1:0]           lane_qnan;
  assign lane_ops  = {op_b, a_eff, op_c};
  assign lane_snan = {cls_b.snan, cls_a.snan, cls_c.snan};
  assign lane_qnan = {cls_b.qnan, cls_a.qnan, cls_c.qnan};

  logic            nan_hit;
  logic            snan_hit;
  logic [FP_W-1:0] nan_val;
  fmasp_nan_pick #(.NOPS(N_OPS)) u_pick (
    .ops      (lane_ops),
    .is_snan  (lane_snan),
    .is_qnan  (lane_qnan),
    .nan_hit  (nan_hit),
    .snan_hit (snan_hit),
    .nan_val  (nan_val)
  );

  logic zinf, inf_clash, inf_hit, inf_sgn;
  fmasp_inf_resolve u_inf (
    .cls_a     (cls_a),
    .cls_b     (cls_b),
    .cls_c     (cls_c),
    .neg_prod  (neg_prod),
    .zinf      (zinf),
    .inf_clash (inf_clash),
    .inf_hit   (inf_hit),
    .inf_sgn   (inf_sgn)
  );

  // next-state
  logic            vld_d;
  logic [FP_W-1:0] res_d;
  logic            inv_d;

  always_comb begin
    vld_d = 1'b0;
    res_d = '0;
    inv_d = 1'b0;
    if (nan_hit) begin
      vld_d = 1'b1;
      res_d = (neg_res && mode == NEG_PREFIX) ? (nan_val ^ SGN_MASK) : nan_val;
      inv_d = snan_hit | (zinf & inv_zinf_qnan);
    end else if (zinf || inf_clash) begin
      vld_d = 1'b1;
      res_d = DEF_QNAN;
      inv_d = 1'b1;
    end else if (inf_hit) begin
      vld_d = 1'b1;
      res_d = INF_MAG | ((inf_sgn ^ neg_res) ? SGN_MASK : '0);
    end
  end

  // output register, always enabled
  logic out_en;
  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_valid  <= 1'b0;
      ovr_result <= '0;
      invalid    <= 1'b0;
    end else if (out_en) begin
      ovr_valid  <= vld_d;
      ovr_result <= res_d;
      invalid    <= inv_d;
    end
  end

  // assertions
  AST_INVALID_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> ovr_valid); // R11

  AST_IDLE_OUTPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_valid |-> (ovr_result == '0)); // R11

  AST_NO_SIGNALING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && (&ovr_result[FP_W-2:FRAC_W]) && (|ovr_result[FRAC_W-1:0]))
      |-> ovr_result[QBIT]); // R2

  AST_SNAN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_snan) |=> (invalid && ovr_valid)); // R2

  AST_ZINF_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (zinf && !cls_c.qnan && !cls_c.snan) |=> (ovr_result == DEF_QNAN && invalid)); // R7

  AST_PLAIN_NO_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|lane_snan) && !(|lane_qnan) && !cls_a.inf && !cls_b.inf && !cls_c.inf)
      |=> !ovr_valid); // R11
endmodule

// File: tb/tb_fma_special_sel.sv
module tb_fma_special_sel;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b, op_c;
  logic        neg_prod, neg_res, neg_mode, inv_zinf_qnan, ftz;
  logic        ovr_valid;
  logic [31:0] ovr_result;
  logic        invalid;

  int n_vec;
  int n_bad;

  fma_special_sel dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .neg_prod(neg_prod), .neg_res(neg_res), .neg_mode(neg_mode),
    .inv_zinf_qnan(inv_zinf_qnan), .ftz(ftz),
    .ovr_valid(ovr_valid), .ovr_result(ovr_result), .invalid(invalid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic        v;
    logic [31:0] r;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic bit f_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit f_inf(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 0);
  endfunction
  function automatic bit f_zero(input logic [31:0] x, input bit fz);
    return (x[30:23] == 0) && ((x[22:0] == 0) || fz);
  endfunction

  function automatic exp_t model(input logic [31:0] a, b, c,
                                 input bit np, nr, md, pol, fz);
    exp_t e;
    logic [31:0] cand[3];
    int pick;
    bit zi, pinf, ps;
    e.v = 0; e.r = 0; e.inv = 0; e.tag = "R11";
    cand[0] = c;
    cand[1] = (np && !md) ? {~a[31], a[30:0]} : a;
    cand[2] = b;
    zi   = (f_zero(a, fz) && f_inf(b)) || (f_inf(a) && f_zero(b, fz));
    pinf = (f_inf(a) || f_inf(b)) && !zi;
    ps   = a[31] ^ b[31] ^ np;
    pick = -1;
    foreach (cand[i]) if (pick < 0 && f_nan(cand[i]) && !cand[i][22]) pick = i;
    if (pick >= 0) begin
      e.inv = 1; e.tag = "R2";
    end else begin
      foreach (cand[i]) if (pick < 0 && f_nan(cand[i])) pick = i;
      if (pick >= 0) begin
        e.tag = zi ? "R6" : "R3";
        e.inv = zi && pol;
      end
    end
    if (pick >= 0) begin
      e.v = 1;
      e.r = cand[pick] | 32'h0040_0000;
      if (nr && !md) e.r[31] = ~e.r[31];
      if (np || nr) e.tag = md ? "R5" : "R4";
      return e;
    end
    if (zi) begin
      e.v = 1; e.r = 32'h7FC0_0000; e.inv = 1; e.tag = fz ? "R10" : "R7";
      return e;
    end
    if (pinf && f_inf(c) && (ps != c[31])) begin
      e.v = 1; e.r = 32'h7FC0_0000; e.inv = 1; e.tag = "R8";
      return e;
    end
    if (pinf || f_inf(c)) begin
      e.v = 1; e.tag = "R9";
      e.r = {(pinf ? ps : c[31]) ^ nr, 8'hFF, 23'd0};
    end
    return e;
  endfunction

  task automatic check_out(input exp_t e);
    n_vec++;
    if (ovr_valid !== e.v || ovr_result !== e.r || invalid !== e.inv) begin
      n_bad++;
      $display("FAIL %s: got v=%b r=%08h inv=%b, expected v=%b r=%08h inv=%b",
               e.tag, ovr_valid, ovr_result, invalid, e.v, e.r, e.inv);
    end
  endtask

  // drive one vector at the falling edge, compare the previous one first
  task automatic apply(input logic [31:0] a, b, c, input bit np, nr, md, pol, fz);
    @(negedge clk);
    if (exp_q.size() > 0) check_out(exp_q.pop_front());
    op_a = a; op_b = b; op_c = c;
    neg_prod = np; neg_res = nr; neg_mode = md; inv_zinf_qnan = pol; ftz = fz;
    exp_q.push_back(model(a, b, c, np, nr, md, pol, fz));
  endtask

  function automatic logic [31:0] rnd_op();
    logic [31:0] x;
    int k;
    x = $urandom;
    k = $urandom_range(0, 6);
    case (k)
      0: x[30:0] = 31'd0;
      1: x[30:0] = {8'hFF, 23'd0};
      2: x[30:22] = 9'h1FF;
      3: begin x[30:22] = {8'hFF, 1'b0}; if (x[21:0] == 0) x[0] = 1'b1; end
      4: begin x[30:23] = 8'h00; if (x[22:0] == 0) x[3] = 1'b1; end
      default: if (x[30:23] == 8'hFF) x[30] = 1'b0;
    endcase
    return x;
  endfunction

  localparam logic [31:0] QA = 32'h7FC0_0A0A, QB = 32'hFFC0_0B0B, QC = 32'h7FC0_0C0C;
  localparam logic [31:0] SA = 32'h7F80_00AA, SB = 32'hFF80_00BB, SC = 32'h7F80_00CC;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, PZ = 32'h0, DEN = 32'h0000_1234;

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_c = '0;
    neg_prod = 0; neg_res = 0; neg_mode = 0; inv_zinf_qnan = 0; ftz = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (ovr_valid !== 1'b0 || ovr_result !== 32'h0 || invalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got v=%b r=%08h inv=%b, expected all zero", ovr_valid, ovr_result, invalid);
    end
    // hold a NaN on the inputs during reset: outputs must stay zero (R1)
    op_c = QC;
    @(negedge clk);
    n_vec++;
    if (ovr_valid !== 1'b0 || ovr_result !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: got v=%b r=%08h under reset, expected 0", ovr_valid, ovr_result);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: signaling priority C, A, B and quieting
    apply(SA, SB, SC, 0, 0, 0, 0, 0);
    apply(SA, SB, QC, 0, 0, 0, 0, 0);
    apply(QA, SB, QC, 0, 0, 0, 0, 0);
    // R3: quiet priority
    apply(QA, QB, QC, 0, 0, 0, 0, 0);
    apply(QA, QB, ONE, 0, 0, 0, 0, 0);
    apply(ONE, QB, PINF, 0, 0, 0, 0, 0);
    // R4: prefix negation flips a propagated NaN
    apply(QA, ONE, ONE, 1, 0, 0, 0, 0);
    apply(ONE, QB, ONE, 1, 0, 0, 0, 0);
    apply(QA, ONE, ONE, 0, 1, 0, 0, 0);
    apply(SA, ONE, ONE, 1, 1, 0, 0, 0);
    // R5: fused negation keeps the sign
    apply(QA, ONE, ONE, 1, 0, 1, 0, 0);
    apply(ONE, ONE, QC, 1, 1, 1, 0, 0);
    // R6: zero x inf + quiet NaN under both policies, both modes
    apply(PZ, PINF, QC, 0, 0, 0, 0, 0);
    apply(PZ, PINF, QC, 0, 0, 0, 1, 0);
    apply(NINF, PZ, 32'hFFC0_0001, 1, 1, 0, 1, 0);
    apply(PZ, PINF, SC, 0, 0, 1, 0, 0);
    // R7: zero x inf + ordinary addend, negations ignored
    apply(PZ, NINF, ONE, 1, 1, 0, 0, 0);
    apply(PINF, PZ, PINF, 0, 0, 1, 0, 0);
    // R8: opposite-signed infinities
    apply(PINF, ONE, NINF, 0, 0, 0, 0, 0);
    apply(PINF, ONE, PINF, 1, 0, 0, 0, 0);
    // R9: signed infinities
    apply(PINF, ONE, PINF, 0, 0, 0, 0, 0);
    apply(NINF, ONE, ONE, 0, 1, 0, 0, 0);
    apply(ONE, ONE, NINF, 1, 1, 1, 0, 0);
    // R10: denormal flushing
    apply(DEN, PINF, ONE, 0, 0, 0, 0, 1);
    apply(DEN, PINF, ONE, 0, 0, 0, 0, 0);
    apply(PINF, DEN, QC, 0, 0, 0, 1, 1);
    // R11: finite operands give no override
    apply(ONE, DEN, PZ, 1, 1, 0, 1, 1);
    apply(ONE, ONE, ONE, 0, 0, 0, 0, 0);

    // random mix of special encodings
    for (int i = 0; i < 3000; i++) begin
      apply(rnd_op(), rnd_op(), rnd_op(), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    if (exp_q.size() > 0) check_out(exp_q.pop_front());

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule